// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is the host side of a single-bit serial flash link. It carries out one flash transaction at a time. A request gives an opcode, a start address, a byte count, a direction flag and a dummy cycle count. The block lowers chip select and clocks out the opcode and the address. It then runs the requested number of idle dummy clocks and moves the data bytes, in either direction. Afterwards it raises chip select and holds it high for a minimum deselect time before it takes the next request.

Two configuration inputs are sampled when a request is accepted. The first selects a 3-byte or a 4-byte address phase. The second selects execute-in-place reads, which leave out the opcode byte so that the address goes out first. The serial clock is the system clock divided by an even parameter. The link uses mode 0: the clock idles low, MOSI changes on the falling edge, MISO is sampled on the rising edge, and bytes go most significant bit first. Each received byte appears on a byte bus with a one-cycle strobe. Each write byte is taken from a byte input, and a one-cycle pulse asks for the next one.

The controller states are:
- IDLE: waiting for a request.
- SETUP: chip select is low and the first bit is on MOSI for half a clock period.
- CMD: the opcode byte.
- ADDR: the address bits.
- DUMMY: idle clocks.
- DATA: the data bytes.
- HOLD: chip select is still low for half a period after the last falling edge.
- GAP: chip select is high for two serial clock periods.

The transitions are:
- IDLE to SETUP when a request is accepted.
- SETUP to CMD, or to ADDR when execute-in-place is set.
- CMD to ADDR.
- ADDR to DUMMY when the dummy count is non-zero. Otherwise ADDR goes to DATA, or to HOLD when the byte count is zero.
- DUMMY to DATA, or to HOLD when the byte count is zero.
- DATA to HOLD after the last byte.
- HOLD to GAP.
- GAP to IDLE.

Top module: `spi_flash_seq`

## Requirements
- R1: While reset is held and in the first cycle after release: spi_cs_n is 1, and spi_sclk, busy, done, rd_valid and wr_take are all 0.
- R2: A request is accepted in a cycle with req_valid high and busy low, unless it is a zero-length read. busy is 1 from the following cycle until the transaction and its deselect gap are over. done is high for exactly one cycle per transaction, and in that cycle busy is 0 and spi_cs_n is 1. spi_cs_n is 0 only while busy is 1.
- R3: In normal mode the rising serial clock edges carry, in order: the 8 opcode bits, then the address bits, then req_dummy dummy bits, then 8 bits per data byte. Every field goes most significant bit first.
- R4: With cfg_addr4 = 1 the address phase is 32 bits and sends req_addr[31:0]. With cfg_addr4 = 0 it is 24 bits and sends req_addr[23:0]. The value is sampled when the request is accepted.
- R5: With cfg_xip = 1 there is no opcode phase, and the first rising edge carries the address MSB.
- R6: spi_sclk is 0 whenever spi_cs_n is 1. spi_mosi does not change while spi_sclk stays high.
- R7: spi_mosi is 0 on every dummy edge and on every data edge of a read.
- R8: On a read, each data byte is built from spi_miso sampled on rising edges, MSB first. It appears on rd_data with rd_valid high for one cycle. There are exactly req_len strobes, in transfer order.
- R9: On a write, wr_data is latched as each data byte begins and sent MSB first. Each latch gives one wr_take pulse, so there are req_len pulses in total.
- R10: spi_cs_n stays 1 for at least 2*CLK_DIV system cycles between two transactions.
- R11: A request raised while busy is 1 is ignored. The running transaction keeps the fields latched at its acceptance.
- R12: A write with req_len = 0 deselects right after the address phase, or after the dummy phase when there is one. A read with req_len = 0 is never accepted: busy stays 0 and spi_cs_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_opcode | input | 8 | Opcode byte |
| req_addr | input | 32 | Start address |
| req_len | input | LEN_W | Number of data bytes |
| req_write | input | 1 | 1 = write data to the flash, 0 = read |
| req_dummy | input | DUMMY_W | Dummy clock count |
| cfg_addr4 | input | 1 | 1 = 4-byte address, 0 = 3-byte address |
| cfg_xip | input | 1 | 1 = leave out the opcode phase |
| wr_data | input | 8 | Next byte to write |
| wr_take | output | 1 | Pulse: wr_data was latched |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Pulse: rd_data holds a new byte |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | Pulse: the transaction has finished |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench models the flash. It records MOSI on every rising edge and drives MISO from a seeded hash of the edge index, so every bit position is checked both against the expected frame and against the received bytes. The corner cases it covers are:
- Zero dummy cycles and the largest dummy count. A design that miscounted here would shift the data by whole clocks and corrupt every read byte.
- Zero-length writes, which would hang or send a stray byte if the length test were misplaced.
- Zero-length reads, which must be refused.
- Execute-in-place with both address widths. A design that kept the opcode would send 8 extra edges.
- Back-to-back requests. These expose a deselect gap that is too short.
- A request raised in the middle of a transaction. A design that sampled it would change the opcode, address or mode part-way through.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_HOLD,
        ST_GAP
    } seq_state_t;

    function automatic logic [31:0] addr_frame(input logic [31:0] addr, input logic wide);
        return wide ? addr : {addr[23:0], 8'h00};
    endfunction
endpackage

// File: rtl/spi_seq_clkgen.sv
module spi_seq_clkgen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic toggle,
    output logic sclk,
    output logic tick,
    output logic rise,
    output logic fall
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF - 1));
    assign rise = tick && toggle && !sclk;
    assign fall = tick && toggle && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else begin
            cnt <= tick ? '0 : cnt + CW'(1);
            if (tick && toggle) begin
                sclk <= ~sclk;
            end
        end
    end
endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] load_val,
    input  logic        shift_out,
    input  logic        shift_in,
    input  logic        miso,
    output logic        msb,
    output logic [7:0]  rx_next
);
    logic [31:0] tx_q;
    logic [7:0]  rx_q;

    assign msb     = tx_q[31];
    assign rx_next = {rx_q[6:0], miso};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (load) begin
                tx_q <= load_val;
            end else if (shift_out) begin
                tx_q <= {tx_q[30:0], 1'b0};
            end
            if (shift_in) begin
                rx_q <= rx_next;
            end
        end
    end
endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
    import spi_seq_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int LEN_W   = 8,
    parameter int DUMMY_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [7:0]         req_opcode,
    input  logic [31:0]        req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic               req_write,
    input  logic [DUMMY_W-1:0] req_dummy,
    input  logic               cfg_addr4,
    input  logic               cfg_xip,
    input  logic [7:0]         wr_data,
    output logic               wr_take,
    output logic [7:0]         rd_data,
    output logic               rd_valid,
    output logic               busy,
    output logic               done,
    output logic               spi_cs_n,
    output logic               spi_sclk,
    output logic               spi_mosi,
    input  logic               spi_miso
);
    localparam int BCW      = (DUMMY_W > 6) ? DUMMY_W : 6;
    localparam int GAP_HALF = 4;

    seq_state_t state, nstate;

    logic [BCW-1:0]     bits_left, bits_nx;
    logic [7:0]         r_op;
    logic [31:0]        r_addr;
    logic [LEN_W-1:0]   r_len;
    logic               r_write, r_addr4, r_xip;
    logic [DUMMY_W-1:0] r_dummy;

    logic sh_load, take_nx, sh_msb;
    logic [31:0] sh_val;
    logic [7:0]  rx_next;
    logic run, toggle, tick, rise, fall, last_bit, accept;
    seq_state_t ent_state;
    logic       ent_load;

    assign accept   = (state == ST_IDLE) && req_valid && (req_write || (req_len != '0)); // R12
    assign last_bit = fall && (bits_left == BCW'(1));
    assign run      = (state != ST_IDLE);
    assign toggle   = (state == ST_CMD) || (state == ST_ADDR) ||
                      (state == ST_DUMMY) || (state == ST_DATA);

    assign ent_state = (r_len == '0) ? ST_HOLD : ST_DATA;
    assign ent_load  = (r_len != '0) && r_write;

    spi_seq_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .toggle (toggle),
        .sclk   (spi_sclk),
        .tick   (tick),
        .rise   (rise),
        .fall   (fall)
    );

    spi_seq_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_val  (sh_val),
        .shift_out (fall),
        .shift_in  (rise),
        .miso      (spi_miso),
        .msb       (sh_msb),
        .rx_next   (rx_next)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // Next state and shifter control
    always_comb begin
        nstate  = state;
        sh_load = 1'b0;
        sh_val  = '0;
        bits_nx = bits_left;
        take_nx = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    nstate  = ST_SETUP;
                    sh_load = 1'b1;
                    if (cfg_xip) begin // R5
                        sh_val  = addr_frame(req_addr, cfg_addr4);
                        bits_nx = cfg_addr4 ? BCW'(32) : BCW'(24);
                    end else begin
                        sh_val  = {req_opcode, 24'h0};
                        bits_nx = BCW'(8);
                    end
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    nstate = r_xip ? ST_ADDR : ST_CMD;
                end
            end
            ST_CMD: begin
                if (last_bit) begin
                    nstate  = ST_ADDR;
                    sh_load = 1'b1;
                    sh_val  = addr_frame(r_addr, r_addr4); // R4
                    bits_nx = r_addr4 ? BCW'(32) : BCW'(24);
                end else if (fall) begin
                    bits_nx = bits_left - BCW'(1);
                end
            end
            ST_ADDR: begin
                if (last_bit) begin
                    if (r_dummy != '0) begin
                        nstate  = ST_DUMMY;
                        bits_nx = BCW'(r_dummy);
                    end else begin
                        nstate  = ent_state;
                        sh_load = ent_load;
                        sh_val  = {wr_data, 24'h0};
                        take_nx = ent_load;
                        bits_nx = BCW'(8);
                    end
                end else if (fall) begin
                    bits_nx = bits_left - BCW'(1);
                end
            end
            ST_DUMMY: begin
                if (last_bit) begin
                    nstate  = ent_state;
                    sh_load = ent_load;
                    sh_val  = {wr_data, 24'h0};
                    take_nx = ent_load;
                    bits_nx = BCW'(8);
                end else if (fall) begin
                    bits_nx = bits_left - BCW'(1);
                end
            end
            ST_DATA: begin
                if (last_bit) begin
                    if (r_len == LEN_W'(1)) begin
                        nstate = ST_HOLD;
                    end else begin
                        bits_nx = BCW'(8);
                        sh_load = r_write; // R9
                        sh_val  = {wr_data, 24'h0};
                        take_nx = r_write;
                    end
                end else if (fall) begin
                    bits_nx = bits_left - BCW'(1);
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    nstate  = ST_GAP;
                    bits_nx = BCW'(GAP_HALF);
                end
            end
            ST_GAP: begin // R10
                if (tick) begin
                    if (bits_left == BCW'(1)) begin
                        nstate = ST_IDLE;
                    end else begin
                        bits_nx = bits_left - BCW'(1);
                    end
                end
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // Registered outputs and latched request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_left <= '0;
            r_op      <= '0;
            r_addr    <= '0;
            r_len     <= '0;
            r_write   <= 1'b0;
            r_addr4   <= 1'b0;
            r_xip     <= 1'b0;
            r_dummy   <= '0;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            done      <= 1'b0;
            wr_take   <= 1'b0;
        end else begin
            bits_left <= bits_nx;
            wr_take   <= take_nx;
            done      <= (state == ST_GAP) && tick && (bits_left == BCW'(1)); // R2
            rd_valid  <= (state == ST_DATA) && !r_write && rise && (bits_left == BCW'(1));
            if ((state == ST_DATA) && !r_write && rise && (bits_left == BCW'(1))) begin
                rd_data <= rx_next; // R8
            end
            if (accept) begin // R11: fields latched only here
                r_op    <= req_opcode;
                r_addr  <= req_addr;
                r_len   <= req_len;
                r_write <= req_write;
                r_addr4 <= cfg_addr4;
                r_xip   <= cfg_xip;
                r_dummy <= req_dummy;
            end else if ((state == ST_DATA) && last_bit) begin
                r_len <= r_len - LEN_W'(1);
            end
        end
    end

    // Pin outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        spi_cs_n = (state == ST_IDLE) || (state == ST_GAP);
        unique case (state)
            ST_SETUP, ST_CMD, ST_ADDR: spi_mosi = sh_msb;
            ST_DATA:                   spi_mosi = r_write && sh_msb; // R7
            default:                   spi_mosi = 1'b0;
        endcase
    end

    logic unused_op;
    assign unused_op = ^r_op;
endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk #(
    parameter int CLK_DIV = 4,
    parameter int LEN_W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [LEN_W-1:0] req_len,
    input logic             req_write,
    input logic             busy,
    input logic             done,
    input logic             rd_valid,
    input logic             cs_n,
    input logic             sclk,
    input logic             mosi
);
    localparam int GW = $clog2(2 * CLK_DIV + 1) + 1;

    logic [GW-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= '1;
        end else if (!cs_n) begin
            gap <= '0;
        end else if (gap != '1) begin
            gap <= gap + GW'(1);
        end
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && (req_write || req_len != '0)) |=> busy); // R2
    AST_SELECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cs_n)); // R2
    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R6
    AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R6
    AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R8
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (gap >= GW'(2 * CLK_DIV))); // R10
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_write && req_len == '0) |=> !busy); // R12
endmodule

bind spi_flash_seq spi_seq_chk #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_len   (req_len),
    .req_write (req_write),
    .busy      (busy),
    .done      (done),
    .rd_valid  (rd_valid),
    .cs_n      (spi_cs_n),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi)
);

// File: tb/sim_spi_flash_seq.sv
module sim_spi_flash_seq;
    localparam int CLK_DIV = 4;
    localparam int LEN_W   = 8;
    localparam int DUMMY_W = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic [7:0]         req_opcode = '0;
    logic [31:0]        req_addr = '0;
    logic [LEN_W-1:0]   req_len = '0;
    logic               req_write = 1'b0;
    logic [DUMMY_W-1:0] req_dummy = '0;
    logic               cfg_addr4 = 1'b0;
    logic               cfg_xip = 1'b0;
    logic [7:0]         wr_data = '0;
    logic               spi_miso = 1'b0;
    logic               wr_take, rd_valid, busy, done, spi_cs_n, spi_sclk, spi_mosi;
    logic [7:0]         rd_data;

    spi_flash_seq #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W), .DUMMY_W(DUMMY_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
        .req_dummy(req_dummy), .cfg_addr4(cfg_addr4), .cfg_xip(cfg_xip),
        .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .done(done), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // flash model state
    int          nrise = 0, nrd = 0, nwt = 0, ndone = 0;
    int          sclk_viol = 0, mosi_viol = 0;
    int          hi_run = 1000, last_gap = 1000;
    logic        mosi_bits [256];
    logic [7:0]  rd_got [16];
    logic [7:0]  wr_bytes [16];
    logic        prev_sclk = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;
    logic [31:0] mseed = '0;

    function automatic logic mbit(input int k);
        logic [31:0] h;
        h = 32'(k) * 32'h9E37_79B1 + mseed;
        return h[17];
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (spi_cs_n && spi_sclk) sclk_viol++;
                if (spi_sclk && prev_sclk && (spi_mosi != prev_mosi)) mosi_viol++;
                if (spi_sclk && !prev_sclk) begin
                    if (nrise < 256) mosi_bits[nrise] = spi_mosi;
                    nrise++;
                end
                if (!spi_sclk && prev_sclk) spi_miso = mbit(nrise);
                if (rd_valid) begin
                    if (nrd < 16) rd_got[nrd] = rd_data;
                    nrd++;
                end
                if (wr_take) begin
                    nwt++;
                    if (nwt < 16) wr_data = wr_bytes[nwt];
                end
                if (done) ndone++;
                if (spi_cs_n) hi_run++;
                if (!spi_cs_n && prev_cs) begin
                    last_gap = hi_run;
                    hi_run = 0;
                end
            end
            prev_sclk = spi_sclk;
            prev_mosi = spi_mosi;
            prev_cs   = spi_cs_n;
        end
    end

    task automatic run_txn(input logic [7:0] op, input logic [31:0] addr, input int len,
                           input bit wr, input int dm, input bit a4, input bit xip, input bit poke);
        logic exp_bits [256];
        int   ne, t, start, bad_op, bad_ad, bad_zero, bad_wr, bad_rd, nab, p_op, p_ad, p_dm;
        logic [7:0] e;
        @(negedge clk);
        nrise = 0; nrd = 0; nwt = 0; ndone = 0; sclk_viol = 0; mosi_viol = 0;
        mseed = $urandom;
        spi_miso = mbit(0);
        for (int i = 0; i < 16; i++) wr_bytes[i] = 8'($urandom);
        wr_data    = wr_bytes[0];
        req_opcode = op; req_addr = addr; req_len = LEN_W'(len); req_write = wr;
        req_dummy  = DUMMY_W'(dm); cfg_addr4 = a4; cfg_xip = xip;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        if (!wr && len == 0) begin
            chk(!busy && spi_cs_n, "R12", $sformatf("empty read busy=%0b cs_n=%0b expected 0/1", busy, spi_cs_n));
            repeat (12) @(negedge clk);
            chk(nrise == 0 && !busy && spi_cs_n, "R12",
                $sformatf("empty read edges=%0d busy=%0b expected 0/0", nrise, busy));
            return;
        end
        chk(busy, "R2", $sformatf("busy=%0b after accept expected 1", busy));
        if (poke) begin
            repeat (20) @(negedge clk);
            req_opcode = ~op; req_addr = ~addr; req_len = LEN_W'(len + 2);
            req_write = ~wr; cfg_xip = ~xip; cfg_addr4 = ~a4; req_dummy = DUMMY_W'(dm + 3);
            req_valid = 1'b1;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        t = 0;
        while (ndone == 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
        chk(ndone == 1 && !busy && spi_cs_n, "R2",
            $sformatf("done=%0d busy=%0b cs_n=%0b expected 1/0/1", ndone, busy, spi_cs_n));
        // expected frame
        ne = 0;
        p_op = 0;
        if (!xip) for (int b = 7; b >= 0; b--) exp_bits[ne++] = op[b];
        p_ad = ne;
        nab = a4 ? 32 : 24;
        for (int b = nab - 1; b >= 0; b--) exp_bits[ne++] = addr[b];
        p_dm = ne;
        for (int b = 0; b < dm; b++) exp_bits[ne++] = 1'b0;
        start = ne;
        for (int j = 0; j < len; j++)
            for (int b = 7; b >= 0; b--) exp_bits[ne++] = wr ? wr_bytes[j][b] : 1'b0;
        chk(nrise == ne, xip ? "R5" : "R3", $sformatf("edges=%0d expected %0d", nrise, ne));
        bad_op = 0; bad_ad = 0; bad_zero = 0; bad_wr = 0;
        for (int i = 0; i < ne && i < nrise; i++) begin
            if (mosi_bits[i] !== exp_bits[i]) begin
                if (i < p_ad) bad_op++;
                else if (i < p_dm) bad_ad++;
                else if (i < start || !wr) bad_zero++;
                else bad_wr++;
            end
        end
        if (!xip) chk(bad_op == 0, "R3", $sformatf("opcode bit errors=%0d expected 0", bad_op));
        chk(bad_ad == 0, xip ? "R5" : "R4", $sformatf("address bit errors=%0d expected 0 (width %0d)", bad_ad, nab));
        chk(bad_zero == 0, "R7", $sformatf("nonzero dummy/read MOSI bits=%0d expected 0", bad_zero));
        if (wr) begin
            chk(bad_wr == 0, "R9", $sformatf("write bit errors=%0d expected 0", bad_wr));
            chk(nwt == len, "R9", $sformatf("wr_take pulses=%0d expected %0d", nwt, len));
        end else begin
            chk(nrd == len, "R8", $sformatf("rd_valid pulses=%0d expected %0d", nrd, len));
            bad_rd = 0;
            for (int j = 0; j < len && j < nrd; j++) begin
                e = '0;
                for (int b = 0; b < 8; b++) e = {e[6:0], mbit(start + 8 * j + b)};
                if (rd_got[j] !== e) begin
                    bad_rd++;
                    $display("  byte %0d got %02h expected %02h", j, rd_got[j], e);
                end
            end
            chk(bad_rd == 0, "R8", $sformatf("read byte errors=%0d expected 0", bad_rd));
        end
        chk(last_gap >= 2 * CLK_DIV, "R10", $sformatf("deselect gap=%0d expected >=%0d", last_gap, 2 * CLK_DIV));
        chk(sclk_viol == 0 && mosi_viol == 0, "R6",
            $sformatf("sclk-while-idle=%0d mosi-while-high=%0d expected 0/0", sclk_viol, mosi_viol));
        if (poke) chk(nrise == ne && ndone == 1, "R11",
            $sformatf("after mid-run request edges=%0d expected %0d", nrise, ne));
        if (wr && len == 0) chk(nrise == ne && nwt == 0, "R12",
            $sformatf("empty write edges=%0d takes=%0d expected %0d/0", nrise, nwt, ne));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(spi_cs_n && !spi_sclk && !busy && !done && !rd_valid && !wr_take, "R1",
            $sformatf("in reset cs_n=%0b sclk=%0b busy=%0b expected 1/0/0", spi_cs_n, spi_sclk, busy));
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n && !spi_sclk && !busy && !done && !rd_valid && !wr_take, "R1",
            $sformatf("after reset cs_n=%0b sclk=%0b busy=%0b expected 1/0/0", spi_cs_n, spi_sclk, busy));
        // directed corners
        run_txn(8'h0B, 32'hA5C3_1E77, 2, 1'b0, 8,  1'b0, 1'b0, 1'b0);
        run_txn(8'h0C, 32'h8123_4567, 3, 1'b0, 8,  1'b1, 1'b0, 1'b0);
        run_txn(8'h03, 32'h00FF_00FF, 1, 1'b0, 0,  1'b0, 1'b0, 1'b0);
        run_txn(8'hEB, 32'hDEAD_BEEF, 2, 1'b0, 31, 1'b1, 1'b1, 1'b0);
        run_txn(8'hEB, 32'h1234_5678, 2, 1'b0, 4,  1'b0, 1'b1, 1'b0);
        run_txn(8'h02, 32'h0000_0100, 3, 1'b1, 0,  1'b0, 1'b0, 1'b0);
        run_txn(8'h20, 32'h0001_0000, 0, 1'b1, 0,  1'b0, 1'b0, 1'b0);
        run_txn(8'h20, 32'h8001_0000, 0, 1'b1, 6,  1'b1, 1'b0, 1'b0);
        run_txn(8'h03, 32'h0000_0000, 0, 1'b0, 0,  1'b0, 1'b0, 1'b0);
        run_txn(8'h0B, 32'h5555_AAAA, 4, 1'b0, 8,  1'b1, 1'b0, 1'b1);
        run_txn(8'h12, 32'hC0FF_EE00, 2, 1'b1, 2,  1'b1, 1'b0, 1'b1);
        // constrained random
        for (int n = 0; n < 24; n++) begin
            bit w;
            w = 1'($urandom % 2);
            run_txn(8'($urandom), $urandom, w ? int'($urandom % 5) : 1 + int'($urandom % 4), w,
                    int'($urandom % 16), 1'($urandom % 2), !w && ($urandom % 3 == 0), 1'b0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2: watchdog expired after 150000 cycles, expected completion sooner");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule